// File: doc/BRIEF.md
# Sensor Interrupt Enable, Routing and Status Unit

This unit sits between the event detectors of a motion sensor and its two interrupt pins. Five event sources feed it. Three of them are conditions that come from the sample buffer and are given as levels: new data present, fill level past its mark, and samples lost. The other two are single-cycle pulses from the motion detectors: motion seen and stillness seen. Each source owns one bit of an 8-bit status register. That bit latches whether or not the source is allowed to interrupt.

A small register port gives access to three registers. The enable register (address 0) decides which latched bits may raise a pin. The routing register (address 1) sends each bit to pin A when the bit is 0 and to pin B when it is 1. The status register (address 2) is read-only. Everything enabled and routed to one pin is ORed onto that pin.

The two kinds of status bit are cleared in different ways. Buffer bits are cleared by the strobe that marks a read of the sample data registers. If their condition is still present at that read, they stay set, so draining the buffer can take several reads. Motion bits, and the interrupts they drive, are cleared by reading the status register.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable, routing and status registers all read 0x00, and both pins are low.
- R2: Bit positions are fixed: bit 7 new data, bit 4 motion, bit 3 stillness, bit 1 fill mark, bit 0 samples lost. Bits 6, 5 and 2 read as 0 in every register. An unused address (3) reads 0x00.
- R3: A write to address 0 or 1 stores the implemented bits of the write data, and those bits read back. A write to address 2 has no effect on the status register.
- R4: A status bit latches when its source is active (a level is high, or a pulse arrives), even while its enable bit is 0. It reads as 1 from the next cycle on.
- R5: A buffer status bit stays set after its level falls, until a data-read strobe arrives. A data-read strobe clears it only when its level is low in that cycle; if the level is still high, the bit stays set.
- R6: A read of address 2 returns the status as it was before the read, then clears the motion and stillness bits. A data-read strobe does not clear those two bits.
- R7: If a motion or stillness pulse arrives in the same cycle as a read of address 2, the bit is set after the read.
- R8: A status bit drives pin A when its enable bit is 1 and its routing bit is 0, drives pin B when both bits are 1, and drives no pin when its enable bit is 0.
- R9: Each pin is the OR of all enabled status bits routed to it. A pin is low only when none of those bits is set.
- R10: A read of address 2 does not clear the buffer status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 clears the motion bits) |
| reg_addr | input | 2 | Register address: 0 enable, 1 routing, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| data_rd | input | 1 | Strobe marking a read of the sample data registers |
| ready_lvl | input | 1 | New data present in the buffer |
| mark_lvl | input | 1 | Buffer fill level at or past its mark |
| ovr_lvl | input | 1 | Buffer has lost samples |
| act_evt | input | 1 | Motion seen (one-cycle pulse) |
| inact_evt | input | 1 | Stillness seen (one-cycle pulse) |
| irq_a | output | 1 | Interrupt pin A |
| irq_b | output | 1 | Interrupt pin B |

## Verification
A status flop stuck at the wrong value shows on the very next status read. It also shows on whichever pin the enable and routing registers point that bit at, in the cycle after the flop updates. The bench therefore compares both the read value and the two pins. It sweeps every combination of latched status with enables off, and every enable and routing combination with all status set. A wrong clear condition, such as the wrong strobe clearing a bit or a pulse lost during a read, survives until the next read. Back-to-back status reads show it within two register accesses.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_EN   = 2'd0,
      SEL_MAP  = 2'd1,
      SEL_SRC  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   function automatic int unsigned count_bits(input logic [31:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) begin
         n += v[i] ? 1 : 0;
      end
      return n;
   endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= wdata & MASK;
      end
   end

   a_r3_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == ($past(wdata) & MASK)));

   a_r3_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/irq_status.sv
module irq_status #(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] LVL_MASK = '0,
   parameter logic [W-1:0] EVT_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         data_rd,
   input  logic         src_rd,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] USED_MASK = LVL_MASK | EVT_MASK;

   logic unused_set;
   assign unused_set = ^(set & ~USED_MASK);

   if ((LVL_MASK & EVT_MASK) != '0) begin : g_bad_overlap
      $error("irq_status: a bit cannot be both level and event type");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LVL_MASK[i]) begin : g_lvl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[i] <= 1'b0;
            end else if (set[i]) begin
               q[i] <= 1'b1;
            end else if (data_rd) begin
               q[i] <= 1'b0;
            end
         end

         a_r4_level_latches : assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
         a_r5_strobe_clears : assert property (@(posedge clk) disable iff (!rst_n)
            (data_rd && !set[i]) |=> !q[i]);
         a_r10_sticky : assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !data_rd) |=> q[i]);
      end else if (EVT_MASK[i]) begin : g_evt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[i] <= 1'b0;
            end else if (set[i]) begin
               q[i] <= 1'b1;
            end else if (src_rd) begin
               q[i] <= 1'b0;
            end
         end

         a_r7_pulse_wins : assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
         a_r6_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
            (src_rd && !set[i]) |=> !q[i]);
         a_r6_strobe_keeps : assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !src_rd) |=> q[i]);
      end else begin : g_none
         assign q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int unsigned W     = 8,
   parameter int unsigned NPINS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     st,
   input  logic [W-1:0]     en,
   input  logic [W-1:0]     map,
   output logic [NPINS-1:0] pin
);

   if (NPINS != 2) begin : g_bad_pins
      $error("irq_route: one routing bit per source selects exactly two pins");
   end

   logic [W-1:0] live;
   assign live = st & en;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [W-1:0] sel;
      if (p == 0) begin : g_a
         assign sel = ~map;
      end else begin : g_b
         assign sel = map;
      end
      assign pin[p] = |(live & sel);

      a_r8_pin_needs_source : assert property (@(posedge clk) disable iff (!rst_n)
         pin[p] |-> ((st & en) != '0));
   end

   a_r9_any_live_drives : assert property (@(posedge clk) disable iff (!rst_n)
      ((st & en) != '0) |-> (pin != '0));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned POS_READY = 7,
   parameter int unsigned POS_ACT   = 4,
   parameter int unsigned POS_INACT = 3,
   parameter int unsigned POS_MARK  = 1,
   parameter int unsigned POS_OVR   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [W-1:0]      reg_wdata,
   output logic [W-1:0]      reg_rdata,
   input  logic              data_rd,
   input  logic              ready_lvl,
   input  logic              mark_lvl,
   input  logic              ovr_lvl,
   input  logic              act_evt,
   input  logic              inact_evt,
   output logic              irq_a,
   output logic              irq_b
);

   localparam logic [W-1:0] ONE      = W'(1);
   localparam logic [W-1:0] LVL_MASK = (ONE << POS_READY) | (ONE << POS_MARK) | (ONE << POS_OVR);
   localparam logic [W-1:0] EVT_MASK = (ONE << POS_ACT) | (ONE << POS_INACT);
   localparam logic [W-1:0] IRQ_MASK = LVL_MASK | EVT_MASK;
   localparam int unsigned  NPINS    = 2;

   if (W < 5 || W > 32) begin : g_bad_width
      $error("irq_hub: register width must hold five sources and fit 32 bits");
   end
   if (POS_READY >= W || POS_ACT >= W || POS_INACT >= W || POS_MARK >= W || POS_OVR >= W) begin : g_bad_pos
      $error("irq_hub: a source position lies outside the register");
   end
   if (count_bits(32'(IRQ_MASK)) != 5) begin : g_bad_dup
      $error("irq_hub: source positions must be distinct");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic en_we, map_we, src_rd;
   assign en_we  = reg_wr && (sel == SEL_EN);
   assign map_we = reg_wr && (sel == SEL_MAP);
   assign src_rd = reg_rd && (sel == SEL_SRC);

   logic [W-1:0] en_q, map_q, st_q, set_vec;

   always_comb begin
      set_vec            = '0;
      set_vec[POS_READY] = ready_lvl;
      set_vec[POS_MARK]  = mark_lvl;
      set_vec[POS_OVR]   = ovr_lvl;
      set_vec[POS_ACT]   = act_evt;
      set_vec[POS_INACT] = inact_evt;
   end

   irq_cfg_reg #(.W(W), .MASK(IRQ_MASK)) i_en (
      .clk(clk), .rst_n(rst_n), .we(en_we), .wdata(reg_wdata), .q(en_q)
   );

   irq_cfg_reg #(.W(W), .MASK(IRQ_MASK)) i_map (
      .clk(clk), .rst_n(rst_n), .we(map_we), .wdata(reg_wdata), .q(map_q)
   );

   irq_status #(.W(W), .LVL_MASK(LVL_MASK), .EVT_MASK(EVT_MASK)) i_status (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .data_rd(data_rd),
      .src_rd(src_rd), .q(st_q)
   );

   logic [NPINS-1:0] pins;

   irq_route #(.W(W), .NPINS(NPINS)) i_route (
      .clk(clk), .rst_n(rst_n), .st(st_q), .en(en_q), .map(map_q), .pin(pins)
   );

   assign irq_a = pins[0];
   assign irq_b = pins[1];

   always_comb begin
      unique case (sel)
         SEL_EN:  reg_rdata = en_q;
         SEL_MAP: reg_rdata = map_q;
         SEL_SRC: reg_rdata = st_q;
         default: reg_rdata = '0;
      endcase
   end

   a_r2_unused_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~IRQ_MASK) == '0);

   a_r3_status_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == SEL_SRC && set_vec == '0 && !data_rd) |=> (st_q & ~$past(st_q)) == '0);

endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       data_rd = 1'b0;
   logic       ready_lvl = 1'b0, mark_lvl = 1'b0, ovr_lvl = 1'b0;
   logic       act_evt = 1'b0, inact_evt = 1'b0;
   logic       irq_a, irq_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_hub i_irq_hub (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .data_rd(data_rd), .ready_lvl(ready_lvl), .mark_lvl(mark_lvl),
      .ovr_lvl(ovr_lvl), .act_evt(act_evt), .inact_evt(inact_evt),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   // compact order {ready, act, inact, mark, ovr} -> bits 7,4,3,1,0
   function automatic logic [7:0] spread(input logic [4:0] v);
      return {v[4], 2'b00, v[3], v[2], 1'b0, v[1], v[0]};
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #0.5 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic strobe_data();
      @(negedge clk);
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
   endtask

   task automatic clear_all();
      logic [7:0] tmp;
      ready_lvl = 1'b0; mark_lvl = 1'b0; ovr_lvl = 1'b0;
      strobe_data();
      rd(2'd2, tmp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk("R1 enable", v, 8'h00);
      rd(2'd1, v); chk("R1 map", v, 8'h00);
      rd(2'd2, v); chk("R1 status", v, 8'h00);
      chk("R1 pins", {6'd0, irq_b, irq_a}, 8'h00);

      // R3 / R2 write-back with unused bits dropped
      wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 enable mask", v, 8'h9B);
      wr(2'd1, 8'h64); rd(2'd1, v); chk("R3 map readback", v, 8'h00);
      wr(2'd1, 8'h5A); rd(2'd1, v); chk("R3 map readback", v, 8'h1A);
      rd(2'd3, v); chk("R2 unused address", v, 8'h00);
      wr(2'd2, 8'hFF); rd(2'd2, v); chk("R3 status write ignored", v, 8'h00);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);

      // R4 sweep: every status pattern latches with enables off, pins stay low (R8)
      for (int s = 0; s < 32; s++) begin
         logic [4:0] p;
         p = 5'(s);
         clear_all();
         @(negedge clk);
         ready_lvl = p[4]; mark_lvl = p[1]; ovr_lvl = p[0];
         act_evt = p[3]; inact_evt = p[2];
         @(negedge clk);
         ready_lvl = 1'b0; mark_lvl = 1'b0; ovr_lvl = 1'b0;
         act_evt = 1'b0; inact_evt = 1'b0;
         @(negedge clk);
         chk("R8 disabled pins low", {6'd0, irq_b, irq_a}, 8'h00);
         rd(2'd2, v); chk("R4 latched regardless of enable", v, spread(p));
         rd(2'd2, v); chk("R10 read keeps buffer bits", v, spread(p & 5'b10011));
      end

      // R5 buffer bits need the level low at the data strobe
      clear_all();
      @(negedge clk); ready_lvl = 1'b1;
      strobe_data();
      rd(2'd2, v); chk("R5 held while level high", v, 8'h80);
      ready_lvl = 1'b0;
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R5 sticky after level falls", v, 8'h80);
      strobe_data();
      rd(2'd2, v); chk("R5 strobe clears", v, 8'h00);

      // R6 data strobe leaves motion bits, status read clears them
      @(negedge clk); act_evt = 1'b1;
      @(negedge clk); act_evt = 1'b0;
      strobe_data();
      rd(2'd2, v); chk("R6 strobe keeps motion", v, 8'h10);
      rd(2'd2, v); chk("R6 read cleared motion", v, 8'h00);

      // R7 pulse coincident with status read survives
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 2'd2; inact_evt = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; inact_evt = 1'b0;
      rd(2'd2, v); chk("R7 pulse during read kept", v, 8'h08);

      // R8/R9 sweep: all status set, every enable x map combination
      clear_all();
      @(negedge clk);
      ready_lvl = 1'b1; mark_lvl = 1'b1; ovr_lvl = 1'b1; act_evt = 1'b1; inact_evt = 1'b1;
      @(negedge clk);
      act_evt = 1'b0; inact_evt = 1'b0;
      for (int e = 0; e < 32; e++) begin
         for (int m = 0; m < 32; m++) begin
            logic ea, eb;
            ea = |(5'(e) & ~5'(m));
            eb = |(5'(e) & 5'(m));
            wr(2'd0, spread(5'(e)));
            wr(2'd1, spread(5'(m)));
            chk("R9 pin OR", {6'd0, irq_b, irq_a}, {6'd0, eb, ea});
         end
      end

      // R8 clearing the source drops the pin
      wr(2'd0, 8'h10); wr(2'd1, 8'h10);
      chk("R8 motion on pin B", {6'd0, irq_b, irq_a}, 8'h02);
      rd(2'd2, v);
      @(negedge clk);
      chk("R8 read drops pin B", {6'd0, irq_b, irq_a}, 8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule